// File: doc/BRIEF.md
# UART Transceiver with Automatic RTS/CTS Flow Control

This block is a compact asynchronous serial transceiver for 7- or 8-bit characters with one start bit, no parity and one stop bit. Characters written by software enter an 8-entry transmit FIFO. A shifter sends them LSB first on `txd_o`. Incoming characters on `rxd_i` are sampled at mid-bit, assembled and stored in an 8-entry receive FIFO. A 16-bit divisor sets the rate. A baud tick fires every `divisor + 1` clocks, and each bit lasts 8 ticks.

Software accesses the block through a word-indexed register file with plain read and write strobes. Reading the data register pops the receive FIFO. Hardware flow control runs by itself once it is enabled:
- RTS drops when the receive FIFO has no more than a programmed number of free entries.
- The transmitter does not begin a new character while CTS is inactive.

Each of RTS and CTS has its own enable bit and its own polarity bit. The transmit and receive interrupt conditions are merged into one pending output.

Top module: `uart_flow_top`

## Requirements
- R1: After reset these registers read as follows: line status 0x60, extra control 0x03 (receiver and transmitter enabled), line control 0x01 (8-bit characters), extended status 0x38E when `cts_i`=1. Also after reset, `txd_o`=1, `irq_o`=0 and `rts_o`=0.
- R2: Register word indices are: data 0, interrupt enable 1, interrupt identify 2, line control 3, modem control 4, line status 5, modem status 6, scratch 7, extra control 8, extended status 9, baud 10. When line control bit 7 is set, data-register accesses reach divisor bits 7:0 and interrupt-enable accesses reach divisor bits 15:8. The baud register always holds the full 16-bit divisor.
- R3: A transmitted character consists of a low start bit, then the data bits LSB first, then a high stop bit. Each bit lasts 8*(divisor+1) clocks. Line control bit 0 selects 8 data bits (1) or 7 data bits (0). The line idles high.
- R4: A received character is written to the receive FIFO when its stop bit, sampled at mid-bit, is high. In 7-bit mode bit 7 of the received byte reads 0. Line status bit 0 reports data ready. A data-register read with line control bit 7 clear returns the oldest byte and pops it.
- R5: A character that completes while the receive FIFO holds 8 entries is dropped and sets the overrun flag. The flag is line status bit 1 and extended status bit 4. Reading line status clears it.
- R6: Writing interrupt identify bit 1 empties the transmit FIFO. Writing bit 2 empties the receive FIFO.
- R7: `irq_o` is high when either of these holds: enable bit 0 is set and the transmit FIFO is empty, or enable bit 1 is set and the receive FIFO is non-empty. Interrupt identify reads as follows: bit 0 pending, bit 1 transmit cause, bit 2 receive cause.
- R8: RTS source depends on extra control bit 2:
  - When bit 2 is set, RTS is asserted only while free receive entries exceed a level chosen by bits 5:4. The level encodings are 00→3, 01→2, 10→1, 11→4.
  - When bit 2 is clear, RTS follows modem control bit 1.
  - Pin polarity: `rts_o` equals the asserted state XOR extra control bit 6.
- R9: CTS is asserted when `cts_i` XOR extra control bit 7 is 1. Modem status bit 4 and extended status bit 7 report it. With extra control bit 3 set, no new character starts while CTS is deasserted.
- R10: Line control bit 6 holds `txd_o` low.
- R11: With extra control bit 1 clear, no character is sent. With bit 0 clear, no character is received.
- R12: Extended status reports these fields: FIFO fill levels in bits 19:16 (receive) and 27:24 (transmit); full flags; idle flags; TX-done (bit 9). The scratch register stores 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (pops the receive FIFO on a data read) |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt pending |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| rts_o | output | 1 | Request-to-send pin |
| cts_i | input | 1 | Clear-to-send pin |

## Verification
Each kind of corrupted internal state shows at the ports:
- A corrupted FIFO pointer or count shows up as a wrong byte on the next data read, or as a wrong level field in extended status in the very next cycle.
- A shifter fault shows up on `txd_o` within one bit time, where the scoreboard decodes the frame.
- A wrong threshold decode moves `rts_o` combinationally as soon as the extra control register changes. Each threshold code is therefore checked against a fixed receive-FIFO fill of five entries.
- A CTS gating fault makes `txd_o` leave idle while the transmit level stays nonzero.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned OVS    = 8;
  localparam int unsigned SUB_W  = $clog2(OVS);

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 4'd0,
    REG_IER  = 4'd1,
    REG_IIR  = 4'd2,
    REG_LCR  = 4'd3,
    REG_MCR  = 4'd4,
    REG_LSR  = 4'd5,
    REG_MSR  = 4'd6,
    REG_SCR  = 4'd7,
    REG_CTL  = 4'd8,
    REG_STAT = 4'd9,
    REG_BAUD = 4'd10
  } reg_addr_e;

  // threshold code -> free entries at which RTS drops (not numeric order)
  function automatic logic [3:0] rts_free_level(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd3;
      2'b01:   return 4'd2;
      2'b10:   return 4'd1;
      default: return 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/uart_flow_fifo.sv
module uart_flow_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [W-1:0]                 din_i,
  output logic [W-1:0]                 dout_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign count_o = cnt;
  assign dout_o  = mem[rp];

  wire do_push = push_i && !full_o;
  wire do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr_i) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wp] <= din_i;
  end
endmodule

// File: rtl/uart_flow_baud.sv
module uart_flow_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt >= div_i) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + DIV_W'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_flow_tx.sv
module uart_flow_tx import uart_flow_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic [7:0] data_i,
  input  logic       wide_i,
  output logic       take_o,
  output logic       line_o,
  output logic       busy_o
);
  logic [9:0]       sh;
  logic [3:0]       left;
  logic [SUB_W-1:0] sub;

  assign take_o = req_i && !busy_o;
  assign line_o = busy_o ? sh[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      sh     <= '1;
      left   <= '0;
      sub    <= '0;
    end else if (take_o) begin
      busy_o <= 1'b1;
      sh     <= wide_i ? {1'b1, data_i, 1'b0} : {2'b11, data_i[6:0], 1'b0};
      left   <= wide_i ? 4'd10 : 4'd9;
      sub    <= '0;
    end else if (busy_o && tick_i) begin
      sub <= sub + SUB_W'(1);
      if (sub == SUB_W'(OVS-1)) begin
        sh   <= {1'b1, sh[9:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_flow_rx.sv
module uart_flow_rx import uart_flow_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       rxd_i,
  input  logic       wide_i,
  output logic       push_o,
  output logic [7:0] data_o,
  output logic       busy_o
);
  logic             s1, s2;
  logic [3:0]       idx;
  logic [SUB_W-1:0] sub;
  logic [7:0]       sh;

  wire [3:0] last = wide_i ? 4'd9 : 4'd8;
  wire       mid  = busy_o && tick_i && (sub == SUB_W'(OVS/2-1));

  assign push_o = mid && (idx == last) && s2;
  assign data_o = wide_i ? sh : {1'b0, sh[7:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      busy_o <= 1'b0;
      idx    <= '0;
      sub    <= '0;
      sh     <= '0;
    end else begin
      s1 <= rxd_i;
      s2 <= s1;
      if (!busy_o) begin
        if (en_i && !s2) begin
          busy_o <= 1'b1;
          idx    <= '0;
          sub    <= '0;
        end
      end else if (tick_i) begin
        sub <= sub + SUB_W'(1);
        if (mid) begin
          if (idx == 4'd0) begin
            if (s2) busy_o <= 1'b0;  // glitch, not a start bit
          end else if (idx == last) begin
            busy_o <= 1'b0;
          end else begin
            sh <= {s2, sh[7:1]};
          end
        end
        if (sub == SUB_W'(OVS-1)) idx <= idx + 4'd1;
      end
    end
  end
endmodule

// File: rtl/uart_flow_top.sv
module uart_flow_top import uart_flow_pkg::*; #(
  parameter int unsigned DEPTH     = 8,
  parameter logic [15:0] RESET_DIV = 16'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              rts_o,
  input  logic              cts_i
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [15:0] div;
  logic [7:0]  lcr, scr, ctl;
  logic [1:0]  ier;
  logic        mcr_rts, ovr;

  wire wide = lcr[0];
  wire brk  = lcr[6];
  wire dlab = lcr[7];

  wire rx_en    = ctl[0];
  wire tx_en    = ctl[1];
  wire rts_afc  = ctl[2];
  wire cts_afc  = ctl[3];
  wire rts_pol  = ctl[6];
  wire cts_pol  = ctl[7];

  wire unused_wdata = ^wdata_i[31:16];

  wire wr_data = wr_i && (addr_i == REG_DATA);
  wire wr_iir  = wr_i && (addr_i == REG_IIR);
  wire rd_data = rd_i && (addr_i == REG_DATA) && !dlab;
  wire rd_lsr  = rd_i && (addr_i == REG_LSR);

  logic          tick;
  logic          tx_take, tx_line, tx_busy, tx_full, tx_empty;
  logic [7:0]    tx_head;
  logic [CW-1:0] tx_count;
  logic          rx_got, rx_busy, rx_full, rx_empty;
  logic [7:0]    rx_byte, rx_head;
  logic [CW-1:0] rx_count;

  wire tx_clr = wr_iir && wdata_i[1];
  wire rx_clr = wr_iir && wdata_i[2];

  // register file
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div     <= RESET_DIV;
      lcr     <= 8'h01;
      scr     <= '0;
      ctl     <= 8'h03;
      ier     <= '0;
      mcr_rts <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        REG_DATA: if (dlab) div[7:0] <= wdata_i[7:0];
        REG_IER:  if (dlab) div[15:8] <= wdata_i[7:0];
                  else      ier <= wdata_i[1:0];
        REG_LCR:  lcr     <= wdata_i[7:0];
        REG_MCR:  mcr_rts <= wdata_i[1];
        REG_SCR:  scr     <= wdata_i[7:0];
        REG_CTL:  ctl     <= wdata_i[7:0];
        REG_BAUD: div     <= wdata_i[15:0];
        default: ;
      endcase
    end
  end

  // overrun: set wins over a same-cycle status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ovr <= 1'b0;
    else if (rx_got && rx_full && !rx_clr) ovr <= 1'b1;
    else if (rd_lsr)                   ovr <= 1'b0;
  end

  uart_flow_baud #(.DIV_W(16)) i_baud (
    .clk_i, .rst_ni, .div_i(div), .tick_o(tick)
  );

  uart_flow_fifo #(.W(8), .DEPTH(DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni, .clr_i(tx_clr),
    .push_i(wr_data && !dlab), .pop_i(tx_take),
    .din_i(wdata_i[7:0]), .dout_o(tx_head), .count_o(tx_count),
    .full_o(tx_full), .empty_o(tx_empty)
  );

  uart_flow_fifo #(.W(8), .DEPTH(DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni, .clr_i(rx_clr),
    .push_i(rx_got), .pop_i(rd_data),
    .din_i(rx_byte), .dout_o(rx_head), .count_o(rx_count),
    .full_o(rx_full), .empty_o(rx_empty)
  );

  // flow control
  wire [CW-1:0] rx_free = CW'(DEPTH) - rx_count;
  wire          rts_act = rts_afc ? (rx_free > CW'(rts_free_level(ctl[5:4]))) : mcr_rts;
  wire          cts_act = cts_i ^ cts_pol;
  assign rts_o = rts_act ^ rts_pol;

  wire tx_req = !tx_empty && !tx_clr && tx_en && (!cts_afc || cts_act);

  uart_flow_tx i_tx (
    .clk_i, .rst_ni, .tick_i(tick), .req_i(tx_req), .data_i(tx_head),
    .wide_i(wide), .take_o(tx_take), .line_o(tx_line), .busy_o(tx_busy)
  );

  uart_flow_rx i_rx (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(rx_en), .rxd_i,
    .wide_i(wide), .push_o(rx_got), .data_o(rx_byte), .busy_o(rx_busy)
  );

  assign txd_o = brk ? 1'b0 : tx_line;

  wire tx_done = tx_empty && !tx_busy;
  wire tx_int  = ier[0] && tx_empty;
  wire rx_int  = ier[1] && !rx_empty;
  assign irq_o = tx_int || rx_int;

  logic [31:0] stat;
  always_comb begin
    stat        = '0;
    stat[0]     = !rx_empty;
    stat[1]     = !tx_full;
    stat[2]     = !rx_busy;
    stat[3]     = !tx_busy;
    stat[4]     = ovr;
    stat[5]     = tx_full;
    stat[6]     = rts_act;
    stat[7]     = cts_act;
    stat[8]     = tx_empty;
    stat[9]     = tx_done;
    stat[19:16] = 4'(rx_count);
    stat[27:24] = 4'(tx_count);
  end

  always_comb begin
    case (addr_i)
      REG_DATA: rdata_o = {24'b0, dlab ? div[7:0] : rx_head};
      REG_IER:  rdata_o = dlab ? {24'b0, div[15:8]} : {30'b0, ier};
      REG_IIR:  rdata_o = {29'b0, rx_int, tx_int, irq_o};
      REG_LCR:  rdata_o = {24'b0, lcr};
      REG_MCR:  rdata_o = {30'b0, mcr_rts, 1'b0};
      REG_LSR:  rdata_o = {25'b0, tx_done, !tx_full, 3'b0, ovr, !rx_empty};
      REG_MSR:  rdata_o = {27'b0, cts_act, 4'b0};
      REG_SCR:  rdata_o = {24'b0, scr};
      REG_CTL:  rdata_o = {24'b0, ctl};
      REG_STAT: rdata_o = stat;
      REG_BAUD: rdata_o = {16'b0, div};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_flow_chk.sv
module uart_flow_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = $clog2(DEPTH+1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_got,
  input logic          rx_full,
  input logic          rx_clr,
  input logic          ovr,
  input logic          cts_afc,
  input logic          cts_act,
  input logic          tx_busy,
  input logic          brk,
  input logic          txd_o,
  input logic          tx_clr,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          rts_afc,
  input logic          rts_pol,
  input logic          rts_o
);
  assert_overrun_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_got && rx_full && !rx_clr |=> ovr);

  assert_rx_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count <= CW'(DEPTH));

  assert_cts_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_afc && !cts_act && !tx_busy |=> !tx_busy);

  assert_idle_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy && !brk |-> txd_o);

  assert_rts_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_afc && rx_count == CW'(DEPTH) |-> rts_o == rts_pol);

  assert_tx_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_clr |=> tx_count == '0);
endmodule

bind uart_flow_top uart_flow_chk #(.DEPTH(DEPTH)) i_uart_flow_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_got(rx_got), .rx_full(rx_full),
  .rx_clr(rx_clr), .ovr(ovr), .cts_afc(cts_afc), .cts_act(cts_act),
  .tx_busy(tx_busy), .brk(brk), .txd_o(txd_o), .tx_clr(tx_clr),
  .tx_count(tx_count), .rx_count(rx_count), .rts_afc(rts_afc),
  .rts_pol(rts_pol), .rts_o(rts_o)
);

// File: tb/test_uart_flow_top.sv
module test_uart_flow_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;  // divisor 1 -> 8 ticks of 2 clocks

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, txd_o, rts_o;
  logic        rxd_i = 1'b1;
  logic        cts_i = 1'b1;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit mon_on = 1'b1;
  bit mon_wide = 1'b1;
  logic [7:0] exp_q[$];
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flow_top i_uart_flow_top (
    .clk_i(clk), .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .irq_o, .txd_o, .rxd_i, .rts_o, .cts_i
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic send_ser(input logic [7:0] b, input bit wide);
    int n = wide ? 8 : 7;
    @(negedge clk);
    rxd_i = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd_i = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxd_i = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic wait_tx_done(input string tag);
    bit ok = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 3000 && !ok; i++) begin
      reg_rd(4'd9, rv);
      if (rv[9] && exp_q.size() == 0) ok = 1'b1;
    end
    chk(tag, 32'(ok), 32'd1);
  endtask

  // scoreboard monitor: decodes txd_o frames and compares against queue
  initial begin
    forever begin
      @(negedge txd_o);
      if (mon_on) begin
        logic [7:0] got;
        int n;
        got = '0;
        n = mon_wide ? 8 : 7;
        repeat (BIT_CLKS/2) @(posedge clk);
        #1 chk("R3 start bit", 32'(txd_o), 32'd0);
        for (int i = 0; i < n; i++) begin
          repeat (BIT_CLKS) @(posedge clk);
          #1 got[i] = txd_o;
        end
        repeat (BIT_CLKS) @(posedge clk);
        #1 chk("R3 stop bit", 32'(txd_o), 32'd1);
        if (exp_q.size() == 0) chk("R3 unexpected frame", 32'(got), 32'hFFFF_FFFF);
        else chk("R3 frame data", 32'(got), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd idle", 32'(txd_o), 32'd1);
    chk("R1 irq", 32'(irq_o), 32'd0);
    chk("R1 rts", 32'(rts_o), 32'd0);
    reg_rd(4'd5, rv); chk("R1 line status", rv, 32'h60);
    reg_rd(4'd8, rv); chk("R1 extra control", rv, 32'h03);
    reg_rd(4'd3, rv); chk("R1 line control", rv, 32'h01);
    reg_rd(4'd9, rv); chk("R1 ext status", rv, 32'h38E);

    // R12 scratch
    reg_wr(4'd7, 32'hA5); reg_rd(4'd7, rv); chk("R12 scratch", rv, 32'hA5);
    reg_wr(4'd7, 32'h1FF); reg_rd(4'd7, rv); chk("R12 scratch width", rv, 32'hFF);

    // R2 divisor latch access
    reg_wr(4'd3, 32'h81);
    reg_wr(4'd0, 32'h01);
    reg_wr(4'd1, 32'h00);
    reg_rd(4'd10, rv); chk("R2 baud via latch", rv, 32'h0001);
    reg_rd(4'd0, rv);  chk("R2 data reads divisor low", rv, 32'h01);
    reg_wr(4'd10, 32'h0000_1234);
    reg_rd(4'd1, rv);  chk("R2 ier reads divisor high", rv, 32'h12);
    reg_wr(4'd10, 32'h0000_0001);
    reg_wr(4'd3, 32'h01);
    reg_rd(4'd1, rv);  chk("R2 ier normal", rv, 32'h0);

    // R3 8-bit transmit
    exp_q.push_back(8'h5A); exp_q.push_back(8'hC3); exp_q.push_back(8'h80);
    reg_wr(4'd0, 32'h5A); reg_wr(4'd0, 32'hC3); reg_wr(4'd0, 32'h80);
    wait_tx_done("R3 8-bit tx done");

    // R3 7-bit transmit
    mon_wide = 1'b0;
    reg_wr(4'd3, 32'h00);
    exp_q.push_back(8'h55);
    reg_wr(4'd0, 32'hD5);
    wait_tx_done("R3 7-bit tx done");
    reg_wr(4'd3, 32'h01);
    mon_wide = 1'b1;

    // R4 receive
    send_ser(8'h3C, 1'b1);
    reg_rd(4'd5, rv); chk("R4 data ready", rv, 32'h61);
    reg_rd(4'd0, rv); chk("R4 rx byte", rv, 32'h3C);
    reg_rd(4'd5, rv); chk("R4 popped", rv, 32'h60);
    reg_wr(4'd3, 32'h00);
    send_ser(8'h81, 1'b0);
    reg_rd(4'd0, rv); chk("R4 7-bit rx", rv, 32'h01);
    reg_wr(4'd3, 32'h01);

    // R5 overrun
    for (int i = 0; i < 9; i++) send_ser(8'(i*17+1), 1'b1);
    reg_rd(4'd9, rv); chk("R5 rx level full", 32'(rv[19:16]), 32'd8);
    chk("R5 ext overrun bit", 32'(rv[4]), 32'd1);
    reg_rd(4'd5, rv); chk("R5 overrun set", 32'(rv[1]), 32'd1);
    reg_rd(4'd5, rv); chk("R5 overrun cleared", 32'(rv[1]), 32'd0);
    for (int i = 0; i < 8; i++) begin
      reg_rd(4'd0, rv); chk("R5 kept byte", rv, 32'(8'(i*17+1)));
    end
    reg_rd(4'd5, rv); chk("R5 ninth dropped", 32'(rv[0]), 32'd0);

    // R8 RTS thresholds at 5 used / 3 free
    for (int i = 0; i < 5; i++) send_ser(8'(8'h40 + i), 1'b1);
    reg_wr(4'd8, 32'h07); @(negedge clk); chk("R8 code00 level3", 32'(rts_o), 32'd0);
    reg_wr(4'd8, 32'h17); @(negedge clk); chk("R8 code01 level2", 32'(rts_o), 32'd1);
    reg_wr(4'd8, 32'h27); @(negedge clk); chk("R8 code10 level1", 32'(rts_o), 32'd1);
    reg_wr(4'd8, 32'h37); @(negedge clk); chk("R8 code11 level4", 32'(rts_o), 32'd0);
    reg_wr(4'd8, 32'h57); @(negedge clk); chk("R8 polarity", 32'(rts_o), 32'd0);
    reg_wr(4'd4, 32'h02); reg_wr(4'd8, 32'h03); @(negedge clk);
    chk("R8 manual rts", 32'(rts_o), 32'd1);
    reg_wr(4'd4, 32'h00);

    // R6 receive clear, RTS recovers
    reg_wr(4'd2, 32'h04);
    reg_rd(4'd9, rv); chk("R6 rx cleared", 32'(rv[19:16]), 32'd0);
    reg_wr(4'd8, 32'h07); @(negedge clk); chk("R8 rts after clear", 32'(rts_o), 32'd1);

    // R11 transmitter disabled, R6 transmit clear
    reg_wr(4'd8, 32'h01);
    reg_wr(4'd0, 32'h11); reg_wr(4'd0, 32'h22);
    repeat (400) @(negedge clk);
    reg_rd(4'd9, rv); chk("R11 tx held", 32'(rv[27:24]), 32'd2);
    chk("R11 txd idle", 32'(txd_o), 32'd1);
    reg_wr(4'd2, 32'h02);
    reg_rd(4'd9, rv); chk("R6 tx cleared", 32'(rv[27:24]), 32'd0);
    reg_wr(4'd8, 32'h03);

    // R11 receiver disabled
    reg_wr(4'd8, 32'h02);
    send_ser(8'h99, 1'b1);
    reg_rd(4'd9, rv); chk("R11 rx ignored", 32'(rv[19:16]), 32'd0);
    reg_wr(4'd8, 32'h03);

    // R9 CTS gating, active-high
    cts_i = 1'b0;
    reg_wr(4'd8, 32'h0B);
    reg_rd(4'd6, rv); chk("R9 msr cts off", rv, 32'h00);
    exp_q.push_back(8'h77);
    reg_wr(4'd0, 32'h77);
    repeat (400) @(negedge clk);
    reg_rd(4'd9, rv); chk("R9 tx held by cts", 32'(rv[27:24]), 32'd1);
    chk("R9 txd idle", 32'(txd_o), 32'd1);
    cts_i = 1'b1;
    reg_rd(4'd6, rv); chk("R9 msr cts on", rv, 32'h10);
    wait_tx_done("R9 tx after cts");
    // inverted polarity
    reg_wr(4'd8, 32'h8B);
    exp_q.push_back(8'hE1);
    reg_wr(4'd0, 32'hE1);
    repeat (400) @(negedge clk);
    reg_rd(4'd9, rv); chk("R9 inverted hold", 32'(rv[27:24]), 32'd1);
    cts_i = 1'b0;
    wait_tx_done("R9 inverted release");
    cts_i = 1'b1;
    reg_wr(4'd8, 32'h03);

    // R7 interrupts
    reg_wr(4'd1, 32'h02);
    chk("R7 rx irq idle", 32'(irq_o), 32'd0);
    send_ser(8'h5E, 1'b1);
    chk("R7 rx irq", 32'(irq_o), 32'd1);
    reg_rd(4'd2, rv); chk("R7 iir rx", rv, 32'h5);
    reg_rd(4'd0, rv); chk("R4 irq byte", rv, 32'h5E);
    @(negedge clk); chk("R7 irq drops", 32'(irq_o), 32'd0);
    reg_wr(4'd1, 32'h01);
    chk("R7 tx irq", 32'(irq_o), 32'd1);
    reg_rd(4'd2, rv); chk("R7 iir tx", rv, 32'h3);
    reg_wr(4'd1, 32'h00);

    // R10 break
    mon_on = 1'b0;
    reg_wr(4'd3, 32'h41); @(negedge clk); chk("R10 break low", 32'(txd_o), 32'd0);
    reg_wr(4'd3, 32'h01); @(negedge clk); chk("R10 break off", 32'(txd_o), 32'd1);
    mon_on = 1'b1;

    chk("R3 queue drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule